// File: doc/BRIEF.md
# Dual Programmable Interval Timer

This block holds two independent down-counters behind one 32-bit register port and drives one level interrupt. Each counter has a divisor register that holds its reload value, a count register that software can read, and a control register. The control register sets an operation (load, hold or run) and picks which of four prescaled tick strobes, supplied from outside, advances the counter. A running counter steps down by one on each selected tick. When it expires it reloads from its divisor, so it fires periodically.

A shared interrupt unit keeps one sticky status bit per counter. It gates the status through a mask and clears bits when software writes ones to an acknowledge address. The interrupt line is high while any unmasked status bit is set. Software reaches all of this through single-cycle requests. Writes take effect at the clock edge. Read data is combinational in the request cycle.

Top module: `dual_interval_timer`

## Requirements
- R1: After a synchronous active-low reset, both counters read 0 and are held, the mask, raw-status and masked-status registers read 0, and irq is low.
- R2: Word offsets are: counter 0 at 0x00 (divisor), 0x04 (count) and 0x08 (control); counter 1 at 0x10, 0x14 and 0x18; mask at 0x48; acknowledge at 0x4C; raw status at 0x50; masked status at 0x54. Control bits [1:0] hold the operation and bits [4:2] hold the tick source. Read data is valid combinationally in the request cycle.
- R3: Writing a control value whose operation is 0 (load) copies the current divisor into the counter, which is readable from the next cycle. The counter then stays still whatever the ticks do.
- R4: With operation 2 (run) and a tick source code c in 4..7, the counter decrements by one at every edge where tick_strobe[c-4] is high. It does not move on edges where only other strobes are high.
- R5: On a selected tick while running, a count of 1 or 0 expires instead of decrementing. The counter reloads the divisor and status bit n (counter n) is set.
- R6: Operations 1 and 3 hold the counter at its value.
- R7: Tick source codes 0 to 3 select no strobe, so a counter in run mode with such a code never changes.
- R8: Writing the acknowledge offset clears each status bit that is 1 in the written data and leaves the others untouched. The acknowledge offset reads as 0.
- R9: If a counter expires in the same cycle that its status bit is acknowledged, the bit ends up set.
- R10: Masked status reads raw status AND mask, irq is high exactly when masked status is nonzero, and a mask write changes irq from the next cycle.
- R11: Reads of the divisor, control and acknowledge offsets and of any unmapped offset return 0. Writes to unmapped offsets change no readable state.
- R12: A control write to a counter in the same cycle as one of its selected ticks takes precedence: the tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A register access is requested this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 8 | Byte offset of the 32-bit register |
| req_wdata | input | 32 | Write data |
| tick_strobe | input | 4 | Prescaled tick strobes; index i serves source code 4+i |
| rdata | output | 32 | Read data, combinational, 0 when no read is requested |
| irq | output | 1 | Level interrupt, high while any unmasked status bit is set |

## Verification
Two pairs of functions can land on the same edge. A counter's expiry can coincide with an acknowledge write to its status bit, and a control write can coincide with a selected tick. The bench forces the first case by arming a counter with divisor 1 and writing the acknowledge together with the tick. It forces the second by rewriting control while the counter's strobe is high. Random traffic then mixes writes and ticks freely so that both pairs recur. A reference model that applies the stated precedence (set over clear, control write over tick) judges the raw status and count reads that follow.

// File: rtl/tmr_pkg.sv
// Package: shared constants and types of the dual interval timer.
// Assumes byte offsets of 32-bit words; counter n lives at n*TMR_STRIDE.
package tmr_pkg;
    localparam int unsigned OFS_DIV    = 'h00;
    localparam int unsigned OFS_CNT    = 'h04;
    localparam int unsigned OFS_CTRL   = 'h08;
    localparam int unsigned TMR_STRIDE = 'h10;
    localparam int unsigned OFS_MASK   = 'h48;
    localparam int unsigned OFS_ACK    = 'h4C;
    localparam int unsigned OFS_RAW    = 'h50;
    localparam int unsigned OFS_MSKD   = 'h54;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_HOLD = 2'd1,
        OP_RUN  = 2'd2,
        OP_RSVD = 2'd3
    } tmr_op_e;
endpackage

// File: rtl/tmr_tick_select.sv
// Module: picks one tick strobe from a source code.
// Codes SRC_BASE..SRC_BASE+NUM_SRC-1 map to strobes 0..NUM_SRC-1;
// every other code yields no tick. Purely combinational.
module tmr_tick_select #(
    parameter int NUM_SRC  = 4,
    parameter int SEL_W    = 3,
    parameter int SRC_BASE = 4
) (
    input  logic [SEL_W-1:0]   sel,
    input  logic [NUM_SRC-1:0] strobes,
    output logic               tick
);
    // Decode the source code into one strobe or none.
    always_comb begin
        tick = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel == SEL_W'(SRC_BASE + i)) tick = strobes[i];
        end
    end
endmodule

// File: rtl/tmr_channel.sv
// Module: one down-counting interval timer.
// Holds divisor, operation and source registers and the counter.
// A control write wins over a tick in the same cycle. A count of 1 or 0
// on a selected running tick expires: expire pulses and the divisor
// reloads. Assumes one write strobe at most per cycle.
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int SEL_W    = 3,
    parameter int NUM_SRC  = 4,
    parameter int SRC_BASE = 4,
    localparam int CTRL_W  = 2 + SEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               div_we,
    input  logic               ctrl_we,
    input  logic [CNT_W-1:0]   div_wdata,
    input  logic [CTRL_W-1:0]  ctrl_wdata,
    input  logic [NUM_SRC-1:0] strobes,
    output logic [CNT_W-1:0]   count,
    output logic               expire
);
    logic [CNT_W-1:0] div_q;
    logic [CNT_W-1:0] cnt_q;
    tmr_op_e          op_q;
    logic [SEL_W-1:0] sel_q;
    logic             tick;
    logic             step;
    tmr_op_e          new_op;

    tmr_tick_select #(
        .NUM_SRC (NUM_SRC),
        .SEL_W   (SEL_W),
        .SRC_BASE(SRC_BASE)
    ) u_tick_sel (
        .sel    (sel_q),
        .strobes(strobes),
        .tick   (tick)
    );

    assign new_op = tmr_op_e'(ctrl_wdata[1:0]);
    assign step   = (op_q == OP_RUN) && tick && !ctrl_we;
    assign expire = step && (cnt_q <= CNT_W'(1));
    assign count  = cnt_q;

    // Divisor register: plain storage of the reload value.
    always_ff @(posedge clk) begin
        if (!rst_n)      div_q <= '0;
        else if (div_we) div_q <= div_wdata;
    end

    // Control register: operation and tick source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q  <= OP_HOLD;
            sel_q <= '0;
        end else if (ctrl_we) begin
            op_q  <= new_op;
            sel_q <= ctrl_wdata[CTRL_W-1:2];
        end
    end

    // Counter: load on command, otherwise step down or reload on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)                            cnt_q <= '0;
        else if (ctrl_we && new_op == OP_LOAD) cnt_q <= div_q;
        else if (expire)                       cnt_q <= div_q;
        else if (step)                         cnt_q <= cnt_q - CNT_W'(1);
    end
endmodule

// File: rtl/tmr_irq_unit.sv
// Module: shared interrupt status, mask and acknowledge.
// A status bit is sticky until a one is written to it through the
// acknowledge strobe. A set in the same cycle wins over the clear.
// irq is the OR of status AND mask, taken from registers.
module tmr_irq_unit #(
    parameter int NUM_TMR = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_TMR-1:0] set_evt,
    input  logic               ack_we,
    input  logic               mask_we,
    input  logic [NUM_TMR-1:0] wbits,
    output logic [NUM_TMR-1:0] status,
    output logic [NUM_TMR-1:0] mask,
    output logic               irq
);
    logic [NUM_TMR-1:0] clr;

    assign clr = ack_we ? wbits : '0;

    // Status: clear acknowledged bits, then OR in new expiries.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr) | set_evt;
    end

    // Mask: plain storage written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_we) mask <= wbits;
    end

    assign irq = |(status & mask);
endmodule

// File: rtl/dual_interval_timer.sv
// Module: top of the dual interval timer.
// Decodes single-cycle register requests, instantiates the counters
// and the interrupt unit, and muxes read data combinationally.
// Assumes full-address match: misaligned or unmapped offsets hit nothing.
module dual_interval_timer
    import tmr_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8,
    parameter int NUM_TMR  = 2,
    parameter int NUM_SRC  = 4,
    parameter int SEL_W    = 3,
    parameter int SRC_BASE = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [NUM_SRC-1:0] tick_strobe,
    output logic [DATA_W-1:0]  rdata,
    output logic               irq
);
    localparam int CNT_W  = DATA_W;
    localparam int CTRL_W = 2 + SEL_W;

    logic                          wr;
    logic                          rd;
    logic [NUM_TMR-1:0]            div_we_vec;
    logic [NUM_TMR-1:0]            ctrl_we_vec;
    logic [NUM_TMR-1:0]            expire_vec;
    logic [NUM_TMR-1:0]            status_vec;
    logic [NUM_TMR-1:0]            mask_vec;
    logic [NUM_TMR-1:0][CNT_W-1:0] cnt_all;
    logic                          mask_we;
    logic                          ack_we;

    assign wr      = req_valid && req_write;
    assign rd      = req_valid && !req_write;
    assign mask_we = wr && (req_addr == ADDR_W'(OFS_MASK));
    assign ack_we  = wr && (req_addr == ADDR_W'(OFS_ACK));

    for (genvar n = 0; n < NUM_TMR; n++) begin : g_tmr
        localparam int unsigned BASE = n * TMR_STRIDE;

        assign div_we_vec[n]  = wr && (req_addr == ADDR_W'(BASE + OFS_DIV));
        assign ctrl_we_vec[n] = wr && (req_addr == ADDR_W'(BASE + OFS_CTRL));

        tmr_channel #(
            .CNT_W   (CNT_W),
            .SEL_W   (SEL_W),
            .NUM_SRC (NUM_SRC),
            .SRC_BASE(SRC_BASE)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .div_we    (div_we_vec[n]),
            .ctrl_we   (ctrl_we_vec[n]),
            .div_wdata (req_wdata[CNT_W-1:0]),
            .ctrl_wdata(req_wdata[CTRL_W-1:0]),
            .strobes   (tick_strobe),
            .count     (cnt_all[n]),
            .expire    (expire_vec[n])
        );
    end

    tmr_irq_unit #(
        .NUM_TMR(NUM_TMR)
    ) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_evt(expire_vec),
        .ack_we (ack_we),
        .mask_we(mask_we),
        .wbits  (req_wdata[NUM_TMR-1:0]),
        .status (status_vec),
        .mask   (mask_vec),
        .irq    (irq)
    );

    // Read mux: only counts, mask and the two status views are readable.
    always_comb begin
        rdata = '0;
        if (rd) begin
            for (int n = 0; n < NUM_TMR; n++) begin
                if (req_addr == ADDR_W'(n * TMR_STRIDE + OFS_CNT)) rdata = DATA_W'(cnt_all[n]);
            end
            if (req_addr == ADDR_W'(OFS_MASK)) rdata = DATA_W'(mask_vec);
            if (req_addr == ADDR_W'(OFS_RAW))  rdata = DATA_W'(status_vec);
            if (req_addr == ADDR_W'(OFS_MSKD)) rdata = DATA_W'(status_vec & mask_vec);
        end
    end
endmodule

// File: rtl/tmr_checker.sv
// Module: property checker for the dual interval timer, bound to the top.
// Observes the request port, the strobes, irq and internal nets that
// separate pieces of logic drive (expiry, status, control strobes, counts).
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8,
    parameter int NUM_TMR = 2,
    parameter int NUM_SRC = 4
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           req_valid,
    input logic                           req_write,
    input logic [ADDR_W-1:0]              req_addr,
    input logic [DATA_W-1:0]              req_wdata,
    input logic [NUM_SRC-1:0]             tick_strobe,
    input logic                           irq,
    input logic [NUM_TMR-1:0]             expire_vec,
    input logic [NUM_TMR-1:0]             status_vec,
    input logic [NUM_TMR-1:0]             ctrl_we_vec,
    input logic [NUM_TMR-1:0][DATA_W-1:0] cnt_all
);
    logic wr_mask;
    logic wr_ack;

    assign wr_mask = req_valid && req_write && (req_addr == ADDR_W'(OFS_MASK));
    assign wr_ack  = req_valid && req_write && (req_addr == ADDR_W'(OFS_ACK));

    // R10: clearing the whole mask silences irq on the next cycle.
    p_mask_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mask && req_wdata[NUM_TMR-1:0] == '0) |=> !irq);

    for (genvar n = 0; n < NUM_TMR; n++) begin : g_chk
        // R9: an expiry always leaves its status bit set, ack or not.
        p_set_beats_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
            expire_vec[n] |=> status_vec[n]);

        // R8: an acknowledged bit with no fresh expiry is cleared.
        p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_ack && req_wdata[n] && !expire_vec[n]) |=> !status_vec[n]);

        // R4: without any strobe or control write the count stays put.
        p_count_needs_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (tick_strobe == '0 && !ctrl_we_vec[n]) |=> $stable(cnt_all[n]));

        // R5: an expiry without software action never leaves status clear.
        p_expire_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (expire_vec[n] && !wr_ack) |=> status_vec[n]);
    end
endmodule

bind dual_interval_timer tmr_checker #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .NUM_TMR(NUM_TMR),
    .NUM_SRC(NUM_SRC)
) u_tmr_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .tick_strobe(tick_strobe),
    .irq        (irq),
    .expire_vec (expire_vec),
    .status_vec (status_vec),
    .ctrl_we_vec(ctrl_we_vec),
    .cnt_all    (cnt_all)
);

// File: tb/test_dual_interval_timer.sv
// Bench: directed corner cases then seeded random traffic, judged by a
// reference model built from the requirements.
module test_dual_interval_timer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_write;
    logic [7:0]  req_addr;
    logic [31:0] req_wdata;
    logic [3:0]  tick_strobe;
    logic [31:0] rdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_tag = "";

    // Reference model state
    logic [31:0] m_div [2];
    logic [31:0] m_cnt [2];
    logic [1:0]  m_op  [2];
    logic [2:0]  m_src [2];
    logic [1:0]  m_stat;
    logic [1:0]  m_mask;

    dual_interval_timer i_dual_interval_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .tick_strobe(tick_strobe),
        .rdata      (rdata),
        .irq        (irq)
    );

    always #2 clk = ~clk;

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h04:   return m_cnt[0];
            8'h14:   return m_cnt[1];
            8'h48:   return {30'd0, m_mask};
            8'h50:   return {30'd0, m_stat};
            8'h54:   return {30'd0, m_stat & m_mask};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string addr_tag(input logic [7:0] a);
        case (a)
            8'h04, 8'h14: return "R4";
            8'h50:        return "R5";
            8'h48, 8'h54: return "R10";
            default:      return "R11";
        endcase
    endfunction

    task automatic model_reset();
        for (int t = 0; t < 2; t++) begin
            m_div[t] = 0; m_cnt[t] = 0; m_op[t] = 2'd1; m_src[t] = 0;
        end
        m_stat = 0; m_mask = 0;
    endtask

    // Advance the model by one edge with the stimulus that was applied.
    task automatic model_update(input bit wr, input logic [7:0] a,
                                input logic [31:0] d, input logic [3:0] tk);
        logic [1:0] exp = 2'b00;
        logic [1:0] ack;
        for (int t = 0; t < 2; t++) begin
            bit sel = (m_src[t] >= 3'd4) && tk[m_src[t] - 3'd4];
            bit cw  = wr && (a == 8'(16 * t + 8));
            if (cw) begin
                if (d[1:0] == 2'd0) m_cnt[t] = m_div[t];
                m_op[t]  = d[1:0];
                m_src[t] = d[4:2];
            end else if (m_op[t] == 2'd2 && sel) begin
                if (m_cnt[t] <= 1) begin
                    exp[t] = 1'b1;
                    m_cnt[t] = m_div[t];
                end else begin
                    m_cnt[t] = m_cnt[t] - 1;
                end
            end
            if (wr && a == 8'(16 * t)) m_div[t] = d;
        end
        ack = (wr && a == 8'h4C) ? d[1:0] : 2'b00;
        m_stat = (m_stat & ~ack) | exp;
        if (wr && a == 8'h48) m_mask = d[1:0];
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check just after, update model at posedge.
    task automatic step(input bit wr, input bit rd, input logic [7:0] a,
                        input logic [31:0] d, input logic [3:0] tk);
        @(negedge clk);
        req_valid = wr | rd; req_write = wr; req_addr = a; req_wdata = d; tick_strobe = tk;
        #1;
        if (rd) check((cur_tag != "") ? cur_tag : addr_tag(a), rdata, model_read(a));
        check((cur_tag != "") ? cur_tag : "R10", {31'd0, irq}, {31'd0, |(m_stat & m_mask)});
        @(posedge clk);
        model_update(wr, a, d, tk);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d, input logic [3:0] tk = 4'h0);
        step(1'b1, 1'b0, a, d, tk);
    endtask

    task automatic rd_reg(input logic [7:0] a, input logic [3:0] tk = 4'h0);
        step(1'b0, 1'b1, a, 32'd0, tk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] rd_addrs [8] = '{8'h04, 8'h14, 8'h48, 8'h50, 8'h54, 8'h00, 8'h4C, 8'h24};
        logic [7:0] wr_addrs [7] = '{8'h00, 8'h10, 8'h08, 8'h18, 8'h48, 8'h4C, 8'h2C};
        void'($urandom(32'h5eed_1234));
        req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0; tick_strobe = 0;
        rst_n = 1'b0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        cur_tag = "R1";
        rd_reg(8'h04); rd_reg(8'h14); rd_reg(8'h48); rd_reg(8'h50); rd_reg(8'h54);

        // R2 / R3: divisor load through the map, then load holds against ticks
        cur_tag = "R2";
        wr_reg(8'h00, 32'd5); wr_reg(8'h08, 32'h10); rd_reg(8'h04);
        wr_reg(8'h10, 32'd7); wr_reg(8'h18, 32'h14); rd_reg(8'h14);
        cur_tag = "R3";
        rd_reg(8'h04, 4'hF); rd_reg(8'h04, 4'hF); rd_reg(8'h04);

        // R4: run on source 4 (strobe 0); other strobes do nothing
        cur_tag = "R4";
        wr_reg(8'h08, 32'h12);
        rd_reg(8'h04, 4'b0001); rd_reg(8'h04, 4'b1110); rd_reg(8'h04, 4'b0001); rd_reg(8'h04);

        // R5: keep ticking until expiry, check status and reload
        cur_tag = "R5";
        for (int i = 0; i < 4; i++) rd_reg(8'h04, 4'b0001);
        rd_reg(8'h50); rd_reg(8'h04);

        // R6: hold freezes, including the reserved operation
        cur_tag = "R6";
        wr_reg(8'h08, 32'h11); rd_reg(8'h04, 4'hF); rd_reg(8'h04, 4'hF);
        wr_reg(8'h08, 32'h13); rd_reg(8'h04, 4'hF); rd_reg(8'h04);

        // R7: run with sources 0 and 3 never counts
        cur_tag = "R7";
        wr_reg(8'h08, 32'h02); rd_reg(8'h04, 4'hF); rd_reg(8'h04, 4'hF);
        wr_reg(8'h08, 32'h0E); rd_reg(8'h04, 4'hF); rd_reg(8'h04);

        // R8: write-one-to-clear; zero bits untouched; ack reads zero
        cur_tag = "R8";
        wr_reg(8'h4C, 32'h2); rd_reg(8'h50);
        wr_reg(8'h4C, 32'h1); rd_reg(8'h50); rd_reg(8'h4C);

        // R9: expiry and acknowledge in the same cycle
        cur_tag = "R9";
        wr_reg(8'h00, 32'd1); wr_reg(8'h08, 32'h10); wr_reg(8'h08, 32'h12);
        wr_reg(8'h4C, 32'h1, 4'b0001); rd_reg(8'h50);

        // R10: mask gating and irq
        cur_tag = "R10";
        wr_reg(8'h48, 32'h1); rd_reg(8'h54); rd_reg(8'h48);
        wr_reg(8'h48, 32'h0); rd_reg(8'h54);
        wr_reg(8'h48, 32'h3); wr_reg(8'h4C, 32'h3); rd_reg(8'h54);

        // R11: write-only and unmapped offsets
        cur_tag = "R11";
        wr_reg(8'h20, 32'hFFFF_FFFF); wr_reg(8'h05, 32'hFFFF_FFFF);
        rd_reg(8'h20); rd_reg(8'h00); rd_reg(8'h08); rd_reg(8'h38); rd_reg(8'h4C);
        rd_reg(8'h50); rd_reg(8'h48); rd_reg(8'h04);

        // R12: control write beats a same-cycle tick
        cur_tag = "R12";
        wr_reg(8'h10, 32'd9); wr_reg(8'h18, 32'h14); wr_reg(8'h18, 32'h16);
        rd_reg(8'h14, 4'b0010);
        wr_reg(8'h18, 32'h16, 4'b0010); rd_reg(8'h14);

        // Random phase
        cur_tag = "";
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] tk = 4'($urandom);
            int pick = int'($urandom_range(0, 99));
            if (pick < 20) begin
                logic [7:0] a = wr_addrs[$urandom_range(0, 6)];
                logic [31:0] d;
                case (a)
                    8'h00, 8'h10: d = 32'($urandom_range(0, 6));
                    8'h08, 8'h18: d = {27'd0, 3'($urandom), 2'($urandom)};
                    default:      d = 32'($urandom);
                endcase
                wr_reg(a, d, tk);
            end else begin
                rd_reg(rd_addrs[$urandom_range(0, 7)], tk);
            end
        end

        summary();
        $finish;
    end
endmodule